// File: doc/BRIEF.md
# NaN Format Converter

This block re-encodes a floating-point NaN from one IEEE binary width (half, single or double) into another. The sign and as much of the payload as fits in the destination are kept. The source fraction is first moved into a common intermediate form: a sign bit plus a 64-bit field with the fraction left-aligned at the top. The destination fraction is then taken from the upper end of that field. Widening therefore pads the payload with zeros at the bottom, and narrowing drops its low bits.

A datapath places the block where a conversion instruction meets a NaN operand. The datapath supplies the value, the source and destination width codes and a default-NaN control, all qualified by a valid strobe. One clock later the block returns the converted value, an invalid-operation flag and a not-a-NaN indication. Operands that are not NaNs, including infinities, are not converted. They come back unchanged and are marked as not-NaN, so that the normal conversion path can handle them.

Width codes: 0 = half, 1 = single, 2 = double, 3 = handled as double. The code is presented on each of `src_fmt` and `dst_fmt`.

Top module: `nan_fmt_conv`

## Requirements
- R1: An operand is decoded by its source width. It is a quiet NaN when its exponent field is all ones and the top fraction bit is 1. It is a signaling NaN when the exponent is all ones, the top fraction bit is 0 and the remaining fraction bits are not all zero. Any other operand is not a NaN. Width code 3 is decoded as double.
- R2: `out_invalid` is 1 in the output cycle of a valid signaling-NaN operand and 0 for every other operand. It is also 0 in any cycle that follows a cycle with `in_vld` low.
- R3: A NaN output keeps the source sign, has an all-ones exponent, and takes the top destination-fraction bits of the left-aligned source fraction. A signaling NaN is not quietened by the conversion.
- R4: If the bits kept after narrowing are all zero, the output is the destination default NaN and not an infinity.
- R5: When `dnan_mode` is 1, every NaN output is the destination default NaN: 0x7E00 for half, 0x7FC00000 for single, 0x7FF8000000000000 for double. `out_invalid` still follows R2.
- R6: For an operand that is not a NaN, `out_val` equals the source encoding, `out_notnan` is 1 and `out_invalid` is 0.
- R7: Source bits above the source width are ignored. Output bits above the result width are driven to 0.
- R8: Results appear one clock after the input. `out_vld` is `in_vld` delayed by one cycle, and `out_notnan` and `out_invalid` are 0 whenever `out_vld` is 0.
- R9: A synchronous active-high `rst` clears `out_vld`, `out_invalid`, `out_notnan` and `out_val` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand valid |
| src_val | input | DATA_W | Operand encoding, right-aligned |
| src_fmt | input | 2 | Source width code |
| dst_fmt | input | 2 | Destination width code |
| dnan_mode | input | 1 | Force the default NaN on NaN results |
| out_val | output | DATA_W | Converted value, zero-extended |
| out_invalid | output | 1 | Invalid-operation flag (signaling input) |
| out_notnan | output | 1 | Operand was not a NaN; value passed unchanged |
| out_vld | output | 1 | Result valid |

## Verification
The bench targets narrowing conversions, where the whole payload lies below the kept bits. A design that copied the truncated fraction without checking it would produce an infinity instead of the default NaN. It also feeds signaling NaNs with a single low payload bit and an infinity encoding. A classifier that looked only at the exponent, or only at the top fraction bit, would misjudge these and raise or drop the invalid flag wrongly. Some operands carry garbage above the source width, and some use width code 3, so that a converter which masked or decoded the wrong bits shows up as a wrong `out_val`. Idle cycles with a signaling operand on the bus, and a reset in the middle of traffic, reveal a flag that is not qualified by valid and state that survives reset.

// File: rtl/nanfc_pkg.sv
package nanfc_pkg;

   localparam int CANON_W = 64;
   localparam int NUM_FMT = 3;

   typedef enum logic [1:0] {
      FMT_HALF   = 2'd0,
      FMT_SINGLE = 2'd1,
      FMT_DOUBLE = 2'd2,
      FMT_ALIAS  = 2'd3
   } fp_fmt_e;

   typedef struct packed {
      logic               sign;
      logic [CANON_W-1:0] frac;
   } canon_t;

   function automatic int frac_bits(int idx);
      case (idx)
         0:       return 10;
         1:       return 23;
         default: return 52;
      endcase
   endfunction

   function automatic int exp_bits(int idx);
      case (idx)
         0:       return 5;
         1:       return 8;
         default: return 11;
      endcase
   endfunction

   function automatic logic [1:0] fmt_index(logic [1:0] code);
      return (code == FMT_ALIAS) ? 2'd2 : code;
   endfunction

   function automatic logic exp_all_ones(logic [63:0] v, logic [1:0] idx);
      case (idx)
         2'd0:    return &v[14:10];
         2'd1:    return &v[30:23];
         default: return &v[62:52];
      endcase
   endfunction

endpackage

// File: rtl/nanfc_unpack.sv
module nanfc_unpack
   import nanfc_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] src_val,
   input  logic [1:0]        src_fmt,
   output canon_t            canon,
   output logic              is_nan,
   output logic              is_snan,
   output logic [DATA_W-1:0] src_trim
);

   logic [NUM_FMT-1:0] nan_v;
   logic [NUM_FMT-1:0] snan_v;
   logic [NUM_FMT-1:0] sign_v;
   logic [CANON_W-1:0] frac_v [NUM_FMT];
   logic [DATA_W-1:0]  trim_v [NUM_FMT];
   logic [1:0]         sel;

   generate
      for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
         localparam int FW       = frac_bits(f);
         localparam int EW       = exp_bits(f);
         localparam int SIGN_POS = FW + EW;

         logic exp_ones;
         logic top_bit;
         logic rest_bits;

         assign exp_ones  = &src_val[FW +: EW];
         assign top_bit   = src_val[FW-1];
         assign rest_bits = |src_val[FW-2:0];

         assign nan_v[f]  = exp_ones & (top_bit | rest_bits);
         assign snan_v[f] = exp_ones & ~top_bit & rest_bits;
         assign sign_v[f] = src_val[SIGN_POS];
         assign frac_v[f] = {src_val[FW-1:0], {(CANON_W-FW){1'b0}}};

         always_comb begin
            trim_v[f]                = '0;
            trim_v[f][SIGN_POS:0]    = src_val[SIGN_POS:0];
         end
      end
   endgenerate

   assign sel        = fmt_index(src_fmt);
   assign is_nan     = nan_v[sel];
   assign is_snan    = snan_v[sel];
   assign canon.sign = sign_v[sel];
   assign canon.frac = frac_v[sel];
   assign src_trim   = trim_v[sel];

   // R1
   always_comb begin
      snan_subset_chk: assert (!(is_snan && !is_nan));
   end

endmodule

// File: rtl/nanfc_pack.sv
module nanfc_pack
   import nanfc_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  canon_t            canon,
   input  logic [1:0]        dst_fmt,
   input  logic              dnan_mode,
   output logic [DATA_W-1:0] nan_out
);

   localparam int MIN_KEEP = frac_bits(NUM_FMT-1);

   if (CANON_W < MIN_KEEP + 1) begin : g_bad_canon
      $error("canonical field narrower than the widest fraction");
   end

   logic [DATA_W-1:0] cand_v [NUM_FMT];
   logic [1:0]        sel;
   logic              unused_low;

   assign unused_low = ^canon.frac[CANON_W-MIN_KEEP-1:0];

   generate
      for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
         localparam int FW       = frac_bits(f);
         localparam int EW       = exp_bits(f);
         localparam int SIGN_POS = FW + EW;

         logic [FW-1:0] kept;
         assign kept = canon.frac[CANON_W-1 -: FW];

         always_comb begin
            cand_v[f]          = '0;
            cand_v[f][FW +: EW] = '1;
            if (dnan_mode || (kept == '0)) begin
               cand_v[f][FW-1] = 1'b1;
            end else begin
               cand_v[f][SIGN_POS] = canon.sign;
               cand_v[f][FW-1:0]   = kept;
            end
         end
      end
   endgenerate

   assign sel     = fmt_index(dst_fmt);
   assign nan_out = cand_v[sel];

endmodule

// File: rtl/nan_fmt_conv.sv
module nan_fmt_conv
   import nanfc_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] src_val,
   input  logic [1:0]        src_fmt,
   input  logic [1:0]        dst_fmt,
   input  logic              dnan_mode,
   output logic [DATA_W-1:0] out_val,
   output logic              out_invalid,
   output logic              out_notnan,
   output logic              out_vld
);

   if (DATA_W < 64) begin : g_bad_width
      $error("DATA_W must hold a double encoding");
   end

   canon_t            canon;
   logic              is_nan;
   logic              is_snan;
   logic [DATA_W-1:0] src_trim;
   logic [DATA_W-1:0] nan_word;

   nanfc_unpack #(.DATA_W(DATA_W)) u_unpack (
      .src_val  (src_val),
      .src_fmt  (src_fmt),
      .canon    (canon),
      .is_nan   (is_nan),
      .is_snan  (is_snan),
      .src_trim (src_trim)
   );

   nanfc_pack #(.DATA_W(DATA_W)) u_pack (
      .canon     (canon),
      .dst_fmt   (dst_fmt),
      .dnan_mode (dnan_mode),
      .nan_out   (nan_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld     <= 1'b0;
         out_invalid <= 1'b0;
         out_notnan  <= 1'b0;
         out_val     <= '0;
      end else begin
         out_vld     <= in_vld;
         out_invalid <= in_vld & is_snan;
         out_notnan  <= in_vld & ~is_nan;
         if (in_vld) begin
            out_val <= is_nan ? nan_word : src_trim;
         end
      end
   end

   // R8
   vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> (!out_vld && !out_invalid && !out_notnan));

   // R2
   flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
      out_invalid |-> (out_vld && !out_notnan));

   // R3
   nan_exp_chk: assert property (@(posedge clk) disable iff (rst)
      (out_vld && !out_notnan) |-> exp_all_ones(out_val[63:0], fmt_index($past(dst_fmt))));

   // R7
   half_upper_chk: assert property (@(posedge clk) disable iff (rst)
      (out_vld && !out_notnan && (fmt_index($past(dst_fmt)) == 2'd0)) |-> (out_val[DATA_W-1:16] == '0));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_vld && !out_invalid));

endmodule

// File: tb/sim_nan_fmt_conv.sv
module sim_nan_fmt_conv;

   typedef struct packed {
      logic [63:0] src;
      logic [1:0]  sf;
      logic [1:0]  df;
      logic        dn;
      logic [63:0] expv;
      logic        inv;
      logic        nn;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{64'h7E01, 2'd0, 2'd1, 1'b0, 64'h7FC02000, 1'b0, 1'b0, 4'd3},            // R3 widen quiet
      '{64'hFC01, 2'd0, 2'd1, 1'b0, 64'hFF802000, 1'b1, 1'b0, 4'd2},            // R2 signaling keeps sign
      '{64'h7FC12345, 2'd1, 2'd2, 1'b0, 64'h7FF82468A0000000, 1'b0, 1'b0, 4'd3}, // R3
      '{64'hFFF4000000000001, 2'd2, 2'd0, 1'b0, 64'hFD00, 1'b1, 1'b0, 4'd3},     // R3 narrow
      '{64'h7FF0000000000001, 2'd2, 2'd0, 1'b0, 64'h7E00, 1'b1, 1'b0, 4'd4},     // R4
      '{64'h7FF0000000000400, 2'd2, 2'd1, 1'b0, 64'h7FC00000, 1'b1, 1'b0, 4'd4}, // R4
      '{64'h7E01, 2'd0, 2'd2, 1'b1, 64'h7FF8000000000000, 1'b0, 1'b0, 4'd5},     // R5
      '{64'h7F800001, 2'd1, 2'd0, 1'b1, 64'h7E00, 1'b1, 1'b0, 4'd5},             // R5
      '{64'hDEAD00003F800000, 2'd1, 2'd2, 1'b0, 64'h3F800000, 1'b0, 1'b1, 4'd6}, // R6
      '{64'h7C00, 2'd0, 2'd1, 1'b0, 64'h7C00, 1'b0, 1'b1, 4'd1},                 // R1 infinity
      '{64'h7FF8DEADBEEF0001, 2'd2, 2'd2, 1'b0, 64'h7FF8DEADBEEF0001, 1'b0, 1'b0, 4'd3}, // R3
      '{64'hFFA00000, 2'd1, 2'd1, 1'b0, 64'hFFA00000, 1'b1, 1'b0, 4'd1},         // R1 signaling
      '{64'h7FFC000000000000, 2'd3, 2'd1, 1'b0, 64'h7FE00000, 1'b0, 1'b0, 4'd1}, // R1 alias code
      '{64'hFFFFFFFFFFFF7D00, 2'd0, 2'd3, 1'b0, 64'h7FF4000000000000, 1'b1, 1'b0, 4'd7} // R7 garbage
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0;
   logic [63:0] src_val = '0;
   logic [1:0]  src_fmt = '0;
   logic [1:0]  dst_fmt = '0;
   logic        dnan_mode = 1'b0;
   logic [63:0] out_val;
   logic        out_invalid;
   logic        out_notnan;
   logic        out_vld;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   nan_fmt_conv #(.DATA_W(64)) u0 (
      .clk         (clk),
      .rst         (rst),
      .in_vld      (in_vld),
      .src_val     (src_val),
      .src_fmt     (src_fmt),
      .dst_fmt     (dst_fmt),
      .dnan_mode   (dnan_mode),
      .out_val     (out_val),
      .out_invalid (out_invalid),
      .out_notnan  (out_notnan),
      .out_vld     (out_vld)
   );

   task automatic chk(input string what, input int req, input logic [63:0] act, input logic [63:0] expv);
      n_run++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic settle();
      @(posedge clk);
      #2;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R9 reset state
      chk("reset out_vld", 9, 64'(out_vld), 64'd0);
      chk("reset out_invalid", 9, 64'(out_invalid), 64'd0);
      chk("reset out_notnan", 9, 64'(out_notnan), 64'd0);
      chk("reset out_val", 9, out_val, 64'd0);

      @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         in_vld    = 1'b1;
         src_val   = VECS[i].src;
         src_fmt   = VECS[i].sf;
         dst_fmt   = VECS[i].df;
         dnan_mode = VECS[i].dn;
         settle();
         chk($sformatf("vec %0d value", i), int'(VECS[i].req), out_val, VECS[i].expv);
         chk($sformatf("vec %0d invalid", i), 2, 64'(out_invalid), 64'(VECS[i].inv));
         chk($sformatf("vec %0d notnan", i), 6, 64'(out_notnan), 64'(VECS[i].nn));
         chk($sformatf("vec %0d valid", i), 8, 64'(out_vld), 64'd1);
      end

      // R8 / R2: idle cycle with a signaling operand on the bus
      @(negedge clk);
      in_vld    = 1'b0;
      src_val   = 64'h7D00;
      src_fmt   = 2'd0;
      dst_fmt   = 2'd1;
      dnan_mode = 1'b0;
      settle();
      chk("idle out_vld", 8, 64'(out_vld), 64'd0);
      chk("idle out_invalid", 2, 64'(out_invalid), 64'd0);
      chk("idle out_notnan", 8, 64'(out_notnan), 64'd0);

      // R8: latency of exactly one clock
      @(negedge clk);
      in_vld = 1'b1;
      #1;
      chk("before edge out_vld", 8, 64'(out_vld), 64'd0);
      settle();
      chk("after edge out_vld", 8, 64'(out_vld), 64'd1);
      chk("after edge value", 3, out_val, 64'h7FA00000);
      chk("after edge invalid", 2, 64'(out_invalid), 64'd1);

      // R9: reset in the middle of traffic
      @(negedge clk);
      rst = 1'b1;
      settle();
      chk("midrun reset out_vld", 9, 64'(out_vld), 64'd0);
      chk("midrun reset out_invalid", 9, 64'(out_invalid), 64'd0);
      chk("midrun reset out_val", 9, out_val, 64'd0);
      @(negedge clk);
      rst    = 1'b0;
      in_vld = 1'b0;
      settle();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule